// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Alert

This block keeps six 32-bit event counters for a processor core. Five of them advance on per-cycle event strobes from the core. The last one advances on every clock and so measures elapsed cycles. Software reaches every counter and two control registers through a small register port with a one-cycle write and a combinational read. The control register holds a global freeze, a per-bank exception enable, overflow-condition enables and an alert flag. A second register holds one freeze bit per counter.

A counter overflows when its most significant bit is set and its condition is enabled. While exceptions are armed, an overflow disarms the block at the next clock edge. It also freezes every counter and sets the alert flag. The block then holds an exception request for the core. The core's interrupt-enable input masks that request without cancelling it.

Software can save the control word and restore it later. If it restores the word with the alert flag and the exception enable both set, the exception is raised again. An alert taken before a context switch is therefore never lost. Clearing the alert flag withdraws any request that is still waiting.

Top module: `perfmon_bank`

## Requirements
- R1: After reset all six counters and the freeze register read zero, the control register reads 0x80000000 (global freeze set), and `exc_req` is low.
- R2: When not frozen, counters at addresses 0 to 4 each increment by one on every clock edge where their `evt_in` bit is high. The counter at address 5 increments on every clock edge.
- R3: While control bit 31 (global freeze) is set, no counter changes except by a register write. Bit i of the freeze register (address 7) stops counter i. Control bit 4 stops the counters at addresses 4 and 5. Writing zero to the freeze register and clearing both control bits lets every counter run again.
- R4: A register write to a counter in the same cycle as an increment of that counter loads the written value.
- R5: Suppose control bit 26 (exception enable) is set and a counter has bit 31 set with its condition enabled. Counter 0 uses control bit 15 and counters 1 to 5 use control bit 14. At the next edge bit 26 clears, and bits 31 and 7 (alert) set. A counter preloaded with 0x7FFFFFFE and counting on every cycle reads 0x80000001 once frozen. A counter whose condition is disabled never causes this.
- R6: The exception request becomes pending at the same edge that sets the alert bit. That is one cycle after the counter first shows bit 31 set, never in the cycle of the overflow itself.
- R7: `exc_req` is high only while a request is pending and `irq_en` is high. A pending request survives any time with `irq_en` low and appears as soon as `irq_en` returns high.
- R8: Writing the control register with bits 7 and 26 both set makes a request pending, whether or not one was pending before. Writing bit 7 without bit 26 does not create a new request.
- R9: Writing the control register with bit 7 clear withdraws any pending request.
- R10: Addresses 0 to 5 select the counters, address 6 the control register and address 7 the freeze register. In the control register only bits 31, 26, 15, 14, 11, 7 and 4 are stored; the others read zero. The freeze register keeps only its low six bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 5 | Event strobes for counters at addresses 0 to 4 |
| irq_en | input | 1 | Core interrupt enable; masks `exc_req` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| exc_req | output | 1 | Performance-monitor exception request to the core |

## Verification
The hardest state to reach is a control-register restore that rewrites an alert which is already set, and the request it must raise. To get there, the bench first produces a real overflow with `irq_en` held low. The request then stays pending but unseen. The bench next restores the control word with and without the exception enable, and drops the alert in between, so that each path into and out of the pending state is covered. The overflow itself is swept across every counter and every combination of the two condition-enable bits. Each case starts from 0x7FFFFFFE, so both the firing edge and the value of the frozen counter are checked.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int PM_RW = 32;

    // Control register bit positions (software visible)
    localparam int CB_FRZALL = 31;
    localparam int CB_EXCEN  = 26;
    localparam int CB_CE1    = 15;
    localparam int CB_CEN    = 14;
    localparam int CB_ASYNC  = 11;
    localparam int CB_ALERT  = 7;
    localparam int CB_FRZ56  = 4;

    localparam logic [PM_RW-1:0] CTRL_WMASK =
        (32'd1 << CB_FRZALL) | (32'd1 << CB_EXCEN) | (32'd1 << CB_CE1) |
        (32'd1 << CB_CEN)    | (32'd1 << CB_ASYNC) | (32'd1 << CB_ALERT) |
        (32'd1 << CB_FRZ56);

    localparam logic [PM_RW-1:0] CTRL_RESET = 32'd1 << CB_FRZALL;

    typedef struct packed {
        logic frz_all;
        logic exc_en;
        logic ce_first;
        logic ce_rest;
        logic alert_sync;
        logic alert;
        logic frz_top2;
    } ctrl_fields_t;

    typedef enum logic [1:0] {
        SEL_CTR,
        SEL_CTRL,
        SEL_FRZ,
        SEL_NONE
    } regsel_e;

    function automatic ctrl_fields_t unpack_ctrl(input logic [PM_RW-1:0] w);
        ctrl_fields_t f;
        f.frz_all    = w[CB_FRZALL];
        f.exc_en     = w[CB_EXCEN];
        f.ce_first   = w[CB_CE1];
        f.ce_rest    = w[CB_CEN];
        f.alert_sync = w[CB_ASYNC];
        f.alert      = w[CB_ALERT];
        f.frz_top2   = w[CB_FRZ56];
        return f;
    endfunction

    function automatic regsel_e decode_addr(input int addr, input int nctr);
        if (addr < nctr)       return SEL_CTR;
        if (addr == nctr)      return SEL_CTRL;
        if (addr == nctr + 1)  return SEL_FRZ;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
#(
    parameter int W = PM_RW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         hold,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d;

    always_comb begin
        q_d = q;
        if (wr)
            q_d = wdata;
        else if (inc && !hold)
            q_d = q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_d;
    end

endmodule

// File: rtl/perfmon_regport.sv
module perfmon_regport
    import perfmon_pkg::*;
#(
    parameter int NCTR = 6,
    parameter int AW   = 3
) (
    input  logic                       reg_wr,
    input  logic [AW-1:0]              reg_addr,
    input  logic [NCTR-1:0][PM_RW-1:0] ctr_q,
    input  logic [PM_RW-1:0]           ctrl_q,
    input  logic [NCTR-1:0]            frz_q,
    output logic [NCTR-1:0]            ctr_wr,
    output logic                       ctrl_wr,
    output logic                       frz_wr,
    output logic [PM_RW-1:0]           reg_rdata
);

    regsel_e sel;

    assign sel = decode_addr(int'(reg_addr), NCTR);

    genvar g;
    generate
        for (g = 0; g < NCTR; g++) begin : g_wdec
            assign ctr_wr[g] = reg_wr && (reg_addr == AW'(g));
        end
    endgenerate

    assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
    assign frz_wr  = reg_wr && (sel == SEL_FRZ);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTR: begin
                for (int i = 0; i < NCTR; i++)
                    if (reg_addr == AW'(i)) reg_rdata = ctr_q[i];
            end
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_FRZ:  reg_rdata = {{(PM_RW-NCTR){1'b0}}, frz_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
#(
    parameter int NCTR = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             frz_wr,
    input  logic [PM_RW-1:0] wdata,
    input  logic [NCTR-1:0]  frz_wdata,
    input  logic [NCTR-1:0]  msb,
    input  logic             irq_en,
    output logic [PM_RW-1:0] ctrl_q,
    output logic [NCTR-1:0]  frz_q,
    output logic [NCTR-1:0]  hold,
    output logic             exc_pend,
    output logic             exc_req
);

    ctrl_fields_t     cf;
    logic [NCTR-1:0]  ce_vec;
    logic             ovf_hit;
    logic [PM_RW-1:0] ctrl_d;
    logic [NCTR-1:0]  frz_d;
    logic             pend_d;

    assign cf = unpack_ctrl(ctrl_q);

    // Per-counter overflow-condition enable and freeze gating
    always_comb begin
        for (int i = 0; i < NCTR; i++) begin
            ce_vec[i] = (i == 0) ? cf.ce_first : cf.ce_rest;
            hold[i]   = cf.frz_all || frz_q[i] || (cf.frz_top2 && (i >= NCTR - 2));
        end
    end

    assign ovf_hit = cf.exc_en && |(msb & ce_vec);

    always_comb begin
        ctrl_d = ctrl_q;
        pend_d = exc_pend;
        if (ctrl_wr) begin
            ctrl_d = wdata & CTRL_WMASK;
            // restoring an alert with exceptions armed must raise again
            pend_d = wdata[CB_ALERT] && (wdata[CB_EXCEN] || exc_pend);
        end else if (ovf_hit) begin
            ctrl_d[CB_EXCEN]  = 1'b0;
            ctrl_d[CB_FRZALL] = 1'b1;
            ctrl_d[CB_ALERT]  = 1'b1;
            pend_d            = 1'b1;
        end
    end

    assign frz_d = frz_wr ? frz_wdata : frz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            frz_q    <= '0;
            exc_pend <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            frz_q    <= frz_d;
            exc_pend <= pend_d;
        end
    end

    assign exc_req = exc_pend && irq_en;

endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
    import perfmon_pkg::*;
#(
    parameter int NCTR = 6,
    localparam int AW  = $clog2(NCTR + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCTR-2:0]  evt_in,
    input  logic             irq_en,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [PM_RW-1:0] reg_wdata,
    output logic [PM_RW-1:0] reg_rdata,
    output logic             exc_req
);

    logic [NCTR-1:0][PM_RW-1:0] ctr_q;
    logic [NCTR-1:0]            ctr_wr;
    logic [NCTR-1:0]            inc;
    logic [NCTR-1:0]            hold;
    logic [NCTR-1:0]            msb;
    logic [PM_RW-1:0]           ctrl_q;
    logic [NCTR-1:0]            frz_q;
    logic                       ctrl_wr;
    logic                       frz_wr;
    logic                       exc_pend;

    genvar g;
    generate
        for (g = 0; g < NCTR; g++) begin : g_ctr
            if (g == NCTR - 1) begin : g_cyc
                assign inc[g] = 1'b1;
            end else begin : g_evt
                assign inc[g] = evt_in[g];
            end

            perfmon_counter #(.W(PM_RW)) i_ctr (
                .clk   (clk),
                .rst   (rst),
                .inc   (inc[g]),
                .hold  (hold[g]),
                .wr    (ctr_wr[g]),
                .wdata (reg_wdata),
                .q     (ctr_q[g])
            );

            assign msb[g] = ctr_q[g][PM_RW-1];
        end
    endgenerate

    perfmon_regport #(.NCTR(NCTR), .AW(AW)) i_regport (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ctr_q     (ctr_q),
        .ctrl_q    (ctrl_q),
        .frz_q     (frz_q),
        .ctr_wr    (ctr_wr),
        .ctrl_wr   (ctrl_wr),
        .frz_wr    (frz_wr),
        .reg_rdata (reg_rdata)
    );

    perfmon_ctrl #(.NCTR(NCTR)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .frz_wr    (frz_wr),
        .wdata     (reg_wdata),
        .frz_wdata (reg_wdata[NCTR-1:0]),
        .msb       (msb),
        .irq_en    (irq_en),
        .ctrl_q    (ctrl_q),
        .frz_q     (frz_q),
        .hold      (hold),
        .exc_pend  (exc_pend),
        .exc_req   (exc_req)
    );

endmodule

// File: rtl/perfmon_bank_chk.sv
module perfmon_bank_chk
    import perfmon_pkg::*;
#(
    parameter int NCTR = 6,
    parameter int AW   = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       irq_en,
    input logic                       reg_wr,
    input logic [AW-1:0]              reg_addr,
    input logic [PM_RW-1:0]           reg_wdata,
    input logic                       exc_req,
    input logic [NCTR-1:0][PM_RW-1:0] ctr_q,
    input logic                       frz_all,
    input logic                       exc_en,
    input logic                       alert,
    input logic                       ce_first,
    input logic                       ce_rest,
    input logic                       exc_pend
);

    logic            ctr_write;
    logic            ctl_write;
    logic [NCTR-1:0] armed_msb;

    assign ctr_write = reg_wr && (int'(reg_addr) < NCTR);
    assign ctl_write = reg_wr && (int'(reg_addr) == NCTR);

    always_comb begin
        for (int i = 0; i < NCTR; i++)
            armed_msb[i] = ctr_q[i][PM_RW-1] && ((i == 0) ? ce_first : ce_rest);
    end

    AST_REQ_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> irq_en);  // R7

    AST_PEND_SURVIVES_MASK: assert property (@(posedge clk) disable iff (rst)
        (exc_pend && !irq_en && !ctl_write) |=> exc_pend);  // R7

    AST_OVERFLOW_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (exc_en && (|armed_msb) && !ctl_write) |=> (!exc_en && frz_all && alert && exc_pend));  // R5

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (frz_all && !ctr_write) |=> $stable(ctr_q));  // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        ctr_write |=> (ctr_q[$past(reg_addr)] == $past(reg_wdata)));  // R4

    AST_REARM_RAISES: assert property (@(posedge clk) disable iff (rst)
        (ctl_write && reg_wdata[CB_ALERT] && reg_wdata[CB_EXCEN]) |=> exc_pend);  // R8

    AST_ALERT_CLEAR_WITHDRAWS: assert property (@(posedge clk) disable iff (rst)
        (ctl_write && !reg_wdata[CB_ALERT]) |=> !exc_pend);  // R9

endmodule

bind perfmon_bank perfmon_bank_chk #(.NCTR(NCTR), .AW(AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (irq_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .exc_req   (exc_req),
    .ctr_q     (ctr_q),
    .frz_all   (ctrl_q[perfmon_pkg::CB_FRZALL]),
    .exc_en    (ctrl_q[perfmon_pkg::CB_EXCEN]),
    .alert     (ctrl_q[perfmon_pkg::CB_ALERT]),
    .ce_first  (ctrl_q[perfmon_pkg::CB_CE1]),
    .ce_rest   (ctrl_q[perfmon_pkg::CB_CEN]),
    .exc_pend  (exc_pend)
);

// File: tb/test_perfmon_bank.sv
module test_perfmon_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 6;

    localparam logic [31:0] B_FRZ   = 32'h8000_0000;
    localparam logic [31:0] B_EXC   = 32'h0400_0000;
    localparam logic [31:0] B_CE1   = 32'h0000_8000;
    localparam logic [31:0] B_CEN   = 32'h0000_4000;
    localparam logic [31:0] B_ALERT = 32'h0000_0080;
    localparam logic [31:0] B_F56   = 32'h0000_0010;
    localparam logic [2:0]  A_CTRL  = 3'd6;
    localparam logic [2:0]  A_FRZ   = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  evt_in = '0;
    logic        irq_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exc_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model [NC];

    perfmon_bank i_perfmon_bank (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (evt_in),
        .irq_en    (irq_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .exc_req   (exc_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int j = 0; j < NC; j++) rd("R1 counter", 3'(j), 32'h0);
        rd("R1 ctrl", A_CTRL, B_FRZ);
        rd("R1 freeze", A_FRZ, 32'h0);
        chk("R1 exc_req", {31'b0, exc_req}, 32'h0);

        // R10: register map and writable masks
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd("R10 ctrl mask", A_CTRL, 32'h8400_C890);
        chk("R8 write alert+enable raises", {31'b0, exc_req}, 32'h1);
        wr(A_CTRL, B_FRZ);
        chk("R9 clear alert", {31'b0, exc_req}, 32'h0);
        wr(A_FRZ, 32'hFFFF_FFFF);
        rd("R10 freeze mask", A_FRZ, 32'h0000_003F);
        wr(A_FRZ, 32'h0);
        rd("R10 freeze clear", A_FRZ, 32'h0);
        for (int j = 0; j < NC; j++) begin
            wr(3'(j), 32'hA500_0000 + 32'(j));
            rd("R10 counter map", 3'(j), 32'hA500_0000 + 32'(j));
        end

        // R2/R3: counting sweep over every freeze mask, with and without the top-two freeze
        for (int k = 0; k < 64; k++) begin
            bit f56;
            f56 = (k % 3) == 0;
            evt_in = '0;
            for (int j = 0; j < NC; j++) begin
                wr(3'(j), 32'h0);
                model[j] = 32'h0;
            end
            wr(A_FRZ, 32'(k));
            wr(A_CTRL, f56 ? B_F56 : 32'h0);
            for (int t = 0; t < 8; t++) begin
                evt_in = 5'((k * 7 + t * 13) ^ (t << 1));
                for (int j = 0; j < NC; j++) begin
                    bit act;
                    act = !k[j] && !(f56 && j >= NC - 2);
                    if (act) model[j] += (j == NC - 1) ? 32'd1 : 32'(evt_in[j]);
                end
                tick(1);
            end
            evt_in = '0;
            if (!k[NC-1] && !f56) model[NC-1] += 32'd1;
            wr(A_CTRL, B_FRZ | (f56 ? B_F56 : 32'h0));
            for (int j = 0; j < NC; j++) rd("R2 R3 count", 3'(j), model[j]);
        end
        wr(A_FRZ, 32'h0);

        // R3: global freeze keeps counters still
        evt_in = 5'h1F;
        tick(4);
        for (int j = 0; j < NC; j++) rd("R3 global freeze", 3'(j), model[j]);

        // R4: write beats increment
        wr(A_CTRL, 32'h0);
        for (int j = 0; j < NC; j++) begin
            wr(3'(j), 32'h1234_0000 + 32'(j));
            rd("R4 write priority", 3'(j), 32'h1234_0000 + 32'(j));
        end
        evt_in = '0;
        wr(A_CTRL, B_FRZ);

        // R5/R6: overflow sweep over every counter and condition-enable combination
        for (int i = 0; i < NC; i++) begin
            for (int ce = 0; ce < 4; ce++) begin
                logic [31:0] cebits;
                bit fire;
                cebits = (ce[0] ? B_CE1 : 32'h0) | (ce[1] ? B_CEN : 32'h0);
                fire = (i == 0) ? ce[0] : ce[1];
                evt_in = '0;
                for (int j = 0; j < NC; j++) wr(3'(j), 32'h0);
                wr(3'(i), 32'h7FFF_FFFE);
                if (i < NC - 1) evt_in[i] = 1'b1;
                wr(A_CTRL, B_EXC | cebits);
                tick(2);
                chk("R6 no request at overflow", {31'b0, exc_req}, 32'h0);
                rd("R6 ctrl before alert", A_CTRL, B_EXC | cebits);
                tick(1);
                chk("R5 R6 request", {31'b0, exc_req}, {31'b0, fire});
                rd("R5 ctrl after overflow", A_CTRL,
                   fire ? (B_FRZ | B_ALERT | cebits) : (B_EXC | cebits));
                tick(1);
                rd("R5 frozen counter", 3'(i), fire ? 32'h8000_0001 : 32'h8000_0002);
                evt_in = '0;
                wr(A_CTRL, B_FRZ | cebits);
                chk("R9 alert cleared", {31'b0, exc_req}, 32'h0);
            end
        end

        // R7: request held while masked
        for (int j = 0; j < NC; j++) wr(3'(j), 32'h0);
        wr(3'd0, 32'h8000_0000);
        irq_en = 1'b0;
        wr(A_CTRL, B_EXC | B_CE1);
        chk("R7 masked at arm", {31'b0, exc_req}, 32'h0);
        tick(1);
        rd("R7 alert set while masked", A_CTRL, B_FRZ | B_ALERT | B_CE1);
        tick(3);
        chk("R7 still masked", {31'b0, exc_req}, 32'h0);
        irq_en = 1'b1;
        #1;
        chk("R7 delivered on unmask", {31'b0, exc_req}, 32'h1);

        // R8: restore with alert already pending
        wr(A_CTRL, B_FRZ | B_ALERT | B_EXC);
        chk("R8 rewrite pending alert", {31'b0, exc_req}, 32'h1);
        wr(A_CTRL, B_FRZ);
        chk("R9 withdraw", {31'b0, exc_req}, 32'h0);
        wr(A_CTRL, B_FRZ | B_ALERT);
        chk("R8 alert without enable", {31'b0, exc_req}, 32'h0);
        wr(A_CTRL, B_FRZ | B_ALERT | B_EXC);
        chk("R8 restore raises", {31'b0, exc_req}, 32'h1);

        // R9: withdraw while masked
        irq_en = 1'b0;
        wr(A_CTRL, B_FRZ);
        irq_en = 1'b1;
        #1;
        chk("R9 withdrawn while masked", {31'b0, exc_req}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule